// File: doc/BRIEF.md
# MIL-STD-1553 Word Encoder

This block builds whole MIL-STD-1553 words on a pair of complementary line outputs. Every word spans twenty bit periods. It opens with a three-bit-time sync, which is either a command/status sync or a data sync. Sixteen Manchester-coded data bits follow, most significant first, and an odd parity bit closes the word. A free-running divider turns the system clock, 12 clocks per bit by default, into a 1 MHz shift clock `esc`. All word timing lines up with the edges of `esc`.

Transmit data passes through two register ranks, each split into an upper byte and a lower byte. The first rank follows `din` while the byte's latch input is high and holds while it is low. The second rank takes the first rank's view of the data while the byte's load input is low. It ignores its inputs for as long as `send_data` is high. A subsystem with 8-bit data lines can therefore fill each byte on its own. When `ser_mode` is high, `din[15]` supplies each data bit straight to the encoder, one bit per shift-clock period.

The sequencer has five states:
- ST_IDLE moves to ST_ARMED when `enc_ena_n` is low at a falling edge of `esc`.
- ST_ARMED moves to ST_SYNC at the next rising edge and captures `sync_sel` there.
- ST_SYNC moves to ST_DATA after three bit periods.
- ST_DATA moves to ST_PARITY after sixteen bit periods.
- ST_PARITY moves back to ST_SYNC if `enc_ena_n` was low at the falling edge in the middle of the parity period. Otherwise it moves to ST_IDLE.
- From any state, `mrst_n` low forces ST_IDLE.

Top module: `enc1553_tx`

## Requirements
- R1: `esc` has a period of CLK_PER_BIT clocks. It is high for the first half of each period and low for the second half.
- R2: A low `enc_ena_n` seen at a falling edge of `esc` starts a word. The word's outputs begin on the next rising edge of `esc`, and the word lasts exactly 20 bit periods.
- R3: `sync_sel` is captured at the rising edge that begins the word. Low gives a command/status sync, with `tx_pos` high for 1.5 bit times and then low for 1.5. High gives a data sync, with `tx_pos` low for 1.5 bit times and then high for 1.5.
- R4: A data bit of 1 drives `tx_pos` high in the first half of its period and low in the second half. A 0 drives the opposite. During a word `tx_neg` is always the complement of `tx_pos`, and outside a word both are low.
- R5: Data bits go out with bit 15 first and bit 0 last.
- R6: The bit after the data makes the count of ones across the 16 data bits and the parity bit odd.
- R7: `send_data` is high for exactly the 16 data bit periods of each word. It rises on a rising edge of `esc`.
- R8: If `enc_ena_n` is low at the falling edge in the middle of the parity period, the next word's sync starts immediately after the parity bit. If it is high, the line goes idle.
- R9: A first-rank byte follows `din` while its latch input is high. It keeps its value while the latch input is low.
- R10: A second-rank byte loads while its load input is low and `send_data` is low. It stays unchanged while `send_data` is high.
- R11: Upper (bits 15:8) and lower (bits 7:0) bytes have separate latch and load inputs, and each byte can be loaded without disturbing the other.
- R12: With `ser_mode` high, each data bit is the value of `din[15]` sampled at the rising edge of `esc` that begins that bit's period. Parity covers those bits.
- R13: `mrst_n` low ends any word at the next clock, leaving both lines low and `send_data` low. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_BIT cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrst_n | input | 1 | Synchronous active-low transmit abort |
| enc_ena_n | input | 1 | Active-low request to send a word |
| sync_sel | input | 1 | 1 selects data sync, 0 selects command/status sync |
| ser_mode | input | 1 | 1 takes data bits serially from din[15] |
| din | input | 16 | Parallel transmit data |
| latch_hi | input | 1 | First-rank upper byte transparent when high |
| latch_lo | input | 1 | First-rank lower byte transparent when high |
| load_hi_n | input | 1 | Second-rank upper byte load, active low |
| load_lo_n | input | 1 | Second-rank lower byte load, active low |
| esc | output | 1 | Encoder shift clock at the bit rate |
| send_data | output | 1 | High during the 16 data bit periods |
| tx_pos | output | 1 | Positive line output |
| tx_neg | output | 1 | Negative line output |

## Verification
The bench watches the line at the middle of every half bit and rebuilds the whole word from those samples. A wrong sync polarity, bit order, Manchester phase or parity sense therefore shows up directly as a wrong expected pattern.

Chaining is checked by holding `enc_ena_n` low through a word and requiring the next sync at the very next clock. A design that inserted an idle period, or that sampled `enc_ena_n` at the wrong edge, would miss that slot. The same test tries to load the second rank during data shifting. A design that failed to lock that rank would send a corrupted first word.

Further tests cover a held first rank, byte-wise loading, serial data entry and an abort in mid-word. Each of these fails visibly if the design looks at the wrong data source or loses register contents on abort.

// File: rtl/enc1553_pkg.sv
package enc1553_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SYNC,
        ST_DATA,
        ST_PARITY
    } tx_state_t;

endpackage

// File: rtl/enc1553_timebase.sv
module enc1553_timebase #(
    parameter int CLK_PER_BIT = 12,
    localparam int PW = $clog2(CLK_PER_BIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          esc,
    output logic          bit_start,
    output logic          mid_edge
);

    localparam logic [PW-1:0] LAST_P = PW'(CLK_PER_BIT - 1);
    localparam logic [PW-1:0] HALF_P = PW'(CLK_PER_BIT / 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == LAST_P) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        esc       = (phase < HALF_P);
        bit_start = (phase == LAST_P);
        mid_edge  = (phase == HALF_P - 1'b1);
    end

    // R1: the phase count wraps to zero after the last clock of a bit period
    assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_P) |=> (phase == '0));

endmodule

// File: rtl/enc1553_txregs.sv
module enc1553_txregs #(
    parameter int WORD_W = 16,
    parameter int LANE_W = 8,
    localparam int NL = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic [NL-1:0]     latch,
    input  logic [NL-1:0]     load_n,
    input  logic              send_data,
    output logic [WORD_W-1:0] rank2
);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LANE_W-1:0] r1;
        logic [LANE_W-1:0] r2;
        logic [LANE_W-1:0] r1_view;

        assign r1_view = latch[g] ? din[g*LANE_W +: LANE_W] : r1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r1 <= '0;
            end else if (latch[g]) begin
                r1 <= din[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r2 <= '0;
            end else if (!load_n[g] && !send_data) begin
                r2 <= r1_view;
            end
        end

        assign rank2[g*LANE_W +: LANE_W] = r2;
    end

    // R10: the second rank cannot change while data is being shifted out
    assert_rank2_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(send_data) |-> $stable(rank2));

endmodule

// File: rtl/enc1553_fsm.sv
module enc1553_fsm
    import enc1553_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_BITS   = 3,
    parameter int CLK_PER_BIT = 12,
    localparam int PW = $clog2(CLK_PER_BIT),
    localparam int CW = $clog2((WORD_W > SYNC_BITS) ? WORD_W : SYNC_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              enc_ena_n,
    input  logic              sync_sel,
    input  logic              ser_mode,
    input  logic              ser_in,
    input  logic [WORD_W-1:0] rank2,
    input  logic [PW-1:0]     phase,
    input  logic              bit_start,
    input  logic              mid_edge,
    output logic              send_data,
    output logic              tx_pos,
    output logic              tx_neg
);

    localparam logic [PW-1:0] HALF_P = PW'(CLK_PER_BIT / 2);

    tx_state_t         state, nxt;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     nidx;
    logic [WORD_W-1:0] shifted;
    logic              new_bit;
    logic              data_sync;
    logic              chain;
    logic              cur_bit;
    logic              par_acc;
    logic              half;
    logic              first_part;
    logic              lvl;
    logic              active;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (mid_edge && !enc_ena_n) nxt = ST_ARMED;
            ST_ARMED:  if (bit_start) nxt = ST_SYNC;
            ST_SYNC:   if (bit_start && cnt == CW'(SYNC_BITS - 1)) nxt = ST_DATA;
            ST_DATA:   if (bit_start && cnt == CW'(WORD_W - 1)) nxt = ST_PARITY;
            ST_PARITY: if (bit_start) nxt = chain ? ST_SYNC : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!mrst_n) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next data bit: parallel from the second rank, or serial from din[15]
    always_comb begin
        nidx    = (state == ST_DATA) ? cnt + 1'b1 : '0;
        shifted = rank2 << nidx;
        new_bit = ser_mode ? ser_in : shifted[WORD_W-1];
    end

    // word datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            data_sync <= 1'b0;
            chain     <= 1'b0;
            cur_bit   <= 1'b0;
            par_acc   <= 1'b0;
        end else begin
            if (bit_start) cnt <= (nxt != state) ? '0 : cnt + 1'b1;
            if (nxt == ST_SYNC && state != ST_SYNC) begin
                data_sync <= sync_sel;
                par_acc   <= 1'b0;
            end
            if (!mrst_n)                               chain <= 1'b0;
            else if (mid_edge && state == ST_PARITY)   chain <= !enc_ena_n;
            if (bit_start && nxt == ST_DATA) begin
                cur_bit <= new_bit;
                par_acc <= par_acc ^ new_bit;
            end else if (bit_start && nxt == ST_PARITY) begin
                cur_bit <= ~par_acc;
            end
        end
    end

    // line outputs
    always_comb begin
        half       = (phase >= HALF_P);
        first_part = ({cnt, half} < (CW+1)'(SYNC_BITS));
        lvl        = 1'b0;
        active     = 1'b0;
        unique case (state)
            ST_SYNC: begin
                active = 1'b1;
                lvl    = data_sync ? !first_part : first_part;
            end
            ST_DATA, ST_PARITY: begin
                active = 1'b1;
                lvl    = cur_bit ^ half;
            end
            default: begin
                active = 1'b0;
                lvl    = 1'b0;
            end
        endcase
        tx_pos    = active & lvl;
        tx_neg    = active & ~lvl;
        send_data = (state == ST_DATA);
    end

    // R4: every data bit changes level at mid-bit
    assert_midbit_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && phase == HALF_P) |-> (tx_pos != $past(tx_pos)));

    // R7: send_data rises at the start of a bit period
    assert_sd_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_data) |-> (phase == '0));

    // R7: without an abort, send_data ends only by moving to parity
    assert_sd_to_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(send_data) && $past(mrst_n)) |-> (state == ST_PARITY));

    // R13: an abort leaves the sequencer idle
    assert_abort_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mrst_n) |-> (state == ST_IDLE));

endmodule

// File: rtl/enc1553_tx.sv
module enc1553_tx #(
    parameter int WORD_W      = 16,
    parameter int LANE_W      = 8,
    parameter int SYNC_BITS   = 3,
    parameter int CLK_PER_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              enc_ena_n,
    input  logic              sync_sel,
    input  logic              ser_mode,
    input  logic [WORD_W-1:0] din,
    input  logic              latch_hi,
    input  logic              latch_lo,
    input  logic              load_hi_n,
    input  logic              load_lo_n,
    output logic              esc,
    output logic              send_data,
    output logic              tx_pos,
    output logic              tx_neg
);

    localparam int PW = $clog2(CLK_PER_BIT);

    logic [PW-1:0]     phase;
    logic              bit_start;
    logic              mid_edge;
    logic [WORD_W-1:0] rank2;

    enc1553_timebase #(.CLK_PER_BIT(CLK_PER_BIT)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .esc       (esc),
        .bit_start (bit_start),
        .mid_edge  (mid_edge)
    );

    enc1553_txregs #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .latch     ({latch_hi, latch_lo}),
        .load_n    ({load_hi_n, load_lo_n}),
        .send_data (send_data),
        .rank2     (rank2)
    );

    enc1553_fsm #(
        .WORD_W      (WORD_W),
        .SYNC_BITS   (SYNC_BITS),
        .CLK_PER_BIT (CLK_PER_BIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrst_n    (mrst_n),
        .enc_ena_n (enc_ena_n),
        .sync_sel  (sync_sel),
        .ser_mode  (ser_mode),
        .ser_in    (din[WORD_W-1]),
        .rank2     (rank2),
        .phase     (phase),
        .bit_start (bit_start),
        .mid_edge  (mid_edge),
        .send_data (send_data),
        .tx_pos    (tx_pos),
        .tx_neg    (tx_neg)
    );

endmodule

// File: tb/enc1553_tx_test.sv
module enc1553_tx_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mrst_n = 1'b1;
    logic enc_ena_n = 1'b1;
    logic sync_sel = 1'b0;
    logic ser_mode = 1'b0;
    logic [15:0] din = '0;
    logic latch_hi = 1'b1, latch_lo = 1'b1;
    logic load_hi_n = 1'b1, load_lo_n = 1'b1;
    logic esc, send_data, tx_pos, tx_neg;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int sd_cnt;
    logic pos_s [40];
    logic neg_s [40];
    logic prev_esc;

    // {sync_sel, word}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'hFFFF}, {1'b1, 16'h0000}, {1'b0, 16'hA5A5},
        {1'b1, 16'h8001}, {1'b1, 16'h1234}, {1'b0, 16'h7FFE}
    };

    enc1553_tx uut (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n), .enc_ena_n(enc_ena_n),
        .sync_sel(sync_sel), .ser_mode(ser_mode), .din(din),
        .latch_hi(latch_hi), .latch_lo(latch_lo),
        .load_hi_n(load_hi_n), .load_lo_n(load_lo_n),
        .esc(esc), .send_data(send_data), .tx_pos(tx_pos), .tx_neg(tx_neg)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_word(input logic [15:0] w);
        din = w; latch_hi = 1; latch_lo = 1;
        load_hi_n = 0; load_lo_n = 0;
        repeat (2) @(negedge clk);
        load_hi_n = 1; load_lo_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_start(output bit ok);
        ok = 0;
        for (int k = 0; k < 400; k++) begin
            prev_esc = esc;
            @(negedge clk);
            if (tx_pos || tx_neg) begin ok = 1; break; end
        end
    endtask

    // mode 0: plain; 1: chain first word; 2: serial; 3: chained second word
    task automatic capture(input int mode, input logic [15:0] aux, input logic aux_ss);
        sd_cnt = 0;
        for (int i = 0; i < 240; i++) begin
            if (i % 6 == 3) begin
                pos_s[i/6] = tx_pos;
                neg_s[i/6] = tx_neg;
            end
            if (send_data) sd_cnt++;
            if (mode != 1 && i == 20) enc_ena_n = 1;
            if (mode == 1) begin
                if (i == 60)  begin din = 16'hDEAD; load_hi_n = 0; load_lo_n = 0; end
                if (i == 62)  begin load_hi_n = 1; load_lo_n = 1; end
                if (i == 230) begin din = aux; sync_sel = aux_ss; load_hi_n = 0; load_lo_n = 0; end
                if (i == 232) begin load_hi_n = 1; load_lo_n = 1; end
            end
            if (mode == 2 && i % 12 == 6 && i / 12 >= 2 && i / 12 <= 17)
                din[15] = aux[15 - (i/12 - 2)];
            @(negedge clk);
        end
    endtask

    task automatic check_word(input logic ss, input logic [15:0] w, input string tag);
        logic [39:0] e, a, n;
        logic p;
        for (int h = 0; h < 6; h++) e[39-h] = ss ? (h >= 3) : (h < 3);
        for (int k = 0; k < 16; k++) begin
            e[39-6-2*k] = w[15-k];
            e[39-7-2*k] = ~w[15-k];
        end
        p = ~^w;
        e[1] = p; e[0] = ~p;
        for (int h = 0; h < 40; h++) begin a[39-h] = pos_s[h]; n[39-h] = neg_s[h]; end
        chk(a[39:34] == e[39:34], {tag, " R3 sync"}, a[39:34], e[39:34]);
        chk(a[33:2] == e[33:2], {tag, " R4 R5 data"}, a[33:2], e[33:2]);
        chk(a[1:0] == e[1:0], {tag, " R6 parity"}, a[1:0], e[1:0]);
        chk(n == ~a, {tag, " R4 complement"}, n, ~a);
        chk(sd_cnt == 192, {tag, " R7 send_data length"}, sd_cnt, 192);
    endtask

    task automatic idle_after(input string tag);
        int act;
        act = 0;
        chk(!tx_pos && !tx_neg && !send_data, {tag, " R2 R8 word ends after 20 bits"},
            {tx_pos, tx_neg, send_data}, 0);
        for (int i = 0; i < 24; i++) begin
            if (tx_pos || tx_neg) act++;
            @(negedge clk);
        end
        chk(act == 0, {tag, " R4 lines low when idle"}, act, 0);
    endtask

    task automatic send_word(input logic ss, input logic [15:0] w, input string tag);
        bit ok;
        sync_sel = ss;
        enc_ena_n = 0;
        wait_start(ok);
        chk(ok && esc && !prev_esc, {tag, " R2 start on esc rise"}, {ok, esc, prev_esc}, 3'b110);
        capture(0, 16'h0, 1'b0);
        check_word(ss, w, tag);
        idle_after(tag);
    endtask

    initial begin
        int hi_cnt, rises;
        bit ok;
        logic last;
        repeat (3) @(negedge clk);
        chk(!tx_pos && !tx_neg && !send_data, "R4 R7 reset state", {tx_pos, tx_neg, send_data}, 0);
        rst_n = 1;
        @(negedge clk);

        // R1: shift clock shape
        hi_cnt = 0; rises = 0; last = esc;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (esc) hi_cnt++;
            if (esc && !last) rises++;
            last = esc;
        end
        chk(hi_cnt == 12 && rises == 2, "R1 esc duty and period", {hi_cnt, rises}, {32'd12, 32'd2});

        // table of vectors
        for (int v = 0; v < 6; v++) begin
            load_word(VEC[v][15:0]);
            send_word(VEC[v][16], VEC[v][15:0], $sformatf("vec%0d", v));
        end

        // R8 / R10: back-to-back words, load attempt while shifting
        load_word(16'h0F0F);
        sync_sel = 0;
        enc_ena_n = 0;
        wait_start(ok);
        chk(ok, "R8 first chained word starts", ok, 1);
        capture(1, 16'hF00D, 1'b1);
        check_word(1'b0, 16'h0F0F, "chain1 R10 lockout");
        chk(tx_pos || tx_neg, "R8 next sync follows parity", {tx_pos, tx_neg}, 2'b11);
        capture(3, 16'h0, 1'b0);
        check_word(1'b1, 16'hF00D, "chain2 R8");
        idle_after("chain2");

        // R9: first rank holds while latch low
        din = 16'h5A3C; latch_hi = 1; latch_lo = 1;
        @(negedge clk);
        latch_hi = 0; latch_lo = 0;
        din = 16'hFFFF;
        load_hi_n = 0; load_lo_n = 0;
        repeat (2) @(negedge clk);
        load_hi_n = 1; load_lo_n = 1;
        latch_hi = 1; latch_lo = 1;
        send_word(1'b0, 16'h5A3C, "R9 latch hold");

        // R11: bytes loaded separately
        din = 16'hAB00; load_hi_n = 0;
        repeat (2) @(negedge clk);
        load_hi_n = 1;
        din = 16'h00CD; load_lo_n = 0;
        repeat (2) @(negedge clk);
        load_lo_n = 1;
        send_word(1'b1, 16'hABCD, "R11 byte lanes");

        // R12: serial data on din[15]
        load_word(16'h0000);
        ser_mode = 1;
        sync_sel = 1;
        enc_ena_n = 0;
        wait_start(ok);
        chk(ok, "R12 serial word starts", ok, 1);
        capture(2, 16'hC3A1, 1'b0);
        check_word(1'b1, 16'hC3A1, "R12 serial");
        idle_after("R12");
        ser_mode = 0;

        // R13: abort mid-word, registers retained
        load_word(16'h3C5A);
        sync_sel = 0;
        enc_ena_n = 0;
        wait_start(ok);
        for (int i = 0; i < 100; i++) begin
            if (i == 20) enc_ena_n = 1;
            @(negedge clk);
        end
        chk(send_data, "R13 precondition in data phase", send_data, 1);
        mrst_n = 0;
        @(negedge clk);
        chk(!tx_pos && !tx_neg && !send_data, "R13 abort clears word",
            {tx_pos, tx_neg, send_data}, 0);
        repeat (12) @(negedge clk);
        chk(!tx_pos && !tx_neg, "R13 lines stay low under abort", {tx_pos, tx_neg}, 0);
        mrst_n = 1;
        @(negedge clk);
        send_word(1'b0, 16'h3C5A, "R13 retained");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule